// File: doc/BRIEF.md
# Microcoded control sequencer

This block is the control unit of a small single-bus processor. It walks a microprogram stored as a combinational case table. Each microinstruction carries two groups of fields. One group holds the datapath control bits: bus drivers, register loads, memory strobes, the ALU operation, the register-file select and a small constant. The other group holds the sequencing fields: the kind of next-address step, a jump target, a hold-for-memory flag, a stop flag and an error flag. The control word of the current microinstruction goes straight out to the datapath. Every register load that the word asserts takes effect at the clock edge that ends that cycle.

The built-in microprogram fetches an instruction and then dispatches on the opcode held in the instruction register. It contains three routines: add-immediate, load-word and halt. A step marked for holding repeats itself, with its control word unchanged, until the memory reports that the access is complete. A stop step still drives its own controls for its cycle. From the following cycle the block shows `halted`, and the control word reads zero until reset. An opcode with no routine sends the sequencer to an error-stop address, and this raises `illegal_op` as well as `halted`.

The block has no data stream, so all of its pins are plain level signals with no valid/ready handshake.

Top module: `useq_ctrl`

## Requirements
- R1: The asynchronous active-low reset puts the micro-PC at address 0. While reset is low, and in the cycle after it is released, `ctrl_word` carries the first fetch word 0x449, and `halted` and `illegal_op` are low. The `ctrl_word` bit layout is as follows. Single bits: bit0 PC drive, bit1 PC load, bit2 IR load, bit3 MAR load, bit4 MDR load, bit5 MDR drive, bit6 memory read, bit7 memory write, bit8 register load, bit9 register drive, bit10 Y load, bit11 Y drive, bit12 Z load, bit13 Z drive, bit14 immediate drive. Bits 16:15 are the register select (1 = rs, 2 = rt). Bits 19:17 are the ALU operation (0 = add). Bit20 is the constant drive and bits 24:21 are the constant value.
- R2: Fetch outputs these words on consecutive steps: 0x449, then 0x901000 (constant 4, add, Z load), then 0x2002 (Z drive, PC load), then 0x24 (MDR drive, IR load). It then outputs one dispatch step whose word is 0.
- R3: The hold step of fetch (0x2002) and the hold step of load (0x40) repeat, with the same word, in every cycle that ends with `mem_done` low. The cycle that ends with `mem_done` high moves on to the next step.
- R4: A step with no jump, dispatch or hold is followed by the step at the next address.
- R5: The dispatch step chooses the next routine from `ir_opcode` as sampled at the edge that ends it. Opcode 0x08 selects add-immediate, 0x23 selects load and 0x3F selects halt.
- R6: Add-immediate outputs 0x8600, then 0x5000, then 0x12100. Its last step is an unconditional microjump back to fetch, so the next word is 0x449.
- R7: Load outputs 0x8600, then 0x5000, then 0x2008, then the hold step 0x40, then 0x10120. It then jumps back to fetch.
- R8: The halt routine's stop step outputs word 0 with `halted` still low. From the next cycle `halted` is high and stays high, and `ctrl_word` is 0 whatever the inputs do.
- R9: Any other opcode sends the next step to the all-ones error address, where `halted` and `illegal_op` are still low. One cycle later both are high, and `ctrl_word` stays 0.
- R10: Reset clears `halted` and `illegal_op` and restarts fetch at 0x449.
- R11: `ir_opcode` has no effect on the words of any step other than dispatch.
- R12: `mem_done` has no effect on steps that do not hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_opcode | input | OP_W (6) | Opcode field of the instruction register |
| mem_done | input | 1 | The memory reports that the pending access has completed |
| ctrl_word | output | 25 | Datapath control bits of the current microinstruction |
| halted | output | 1 | The machine has stopped |
| illegal_op | output | 1 | The stop was caused by an opcode that has no routine |

## Verification
The checker relies on `ir_opcode` and `mem_done` holding known values at every rising edge while reset is high. It also relies on the microprogram never placing a plain step at the last address, so that the one-step advance never wraps. The bench changes inputs only on falling edges and releases reset on a falling edge. It gives `ir_opcode` junk values and pulses `mem_done` during steps where these inputs must be ignored. It sets the real opcode before the dispatch edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_AND = 3'd1,
    ALU_XOR = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SHL = 3'd4,
    ALU_LT  = 3'd5,
    ALU_SHR = 3'd6,
    ALU_SUB = 3'd7
  } alu_e;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_S    = 2'd1,
    RSEL_T    = 2'd2,
    RSEL_D    = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    SQ_STEP = 2'd0,
    SQ_GOTO = 2'd1,
    SQ_DISP = 2'd2
  } seq_e;

  // first member is the most significant
  typedef struct packed {
    logic [3:0] konst;
    logic       konst_drv;
    alu_e       alu;
    rsel_e      rsel;
    logic       imm_drv;
    logic       z_drv;
    logic       z_ld;
    logic       y_drv;
    logic       y_ld;
    logic       reg_drv;
    logic       reg_ld;
    logic       mem_wr;
    logic       mem_rd;
    logic       mdr_drv;
    logic       mdr_ld;
    logic       mar_ld;
    logic       ir_ld;
    logic       pc_ld;
    logic       pc_drv;
  } ctrl_t;

  // microprogram layout
  localparam int UA_F0   = 0;
  localparam int UA_F1   = 1;
  localparam int UA_F2   = 2;
  localparam int UA_F3   = 3;
  localparam int UA_DISP = 4;
  localparam int UA_AI0  = 5;
  localparam int UA_AI1  = 6;
  localparam int UA_AI2  = 7;
  localparam int UA_LD0  = 8;
  localparam int UA_LD1  = 9;
  localparam int UA_LD2  = 10;
  localparam int UA_LD3  = 11;
  localparam int UA_LD4  = 12;
  localparam int UA_HALT = 13;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output ctrl_t             ctrl,
  output seq_e              seq,
  output logic              hold,
  output logic              stop,
  output logic              err,
  output logic [ADDR_W-1:0] tgt
);

  always_comb begin
    ctrl = '0;
    seq  = SQ_STEP;
    hold = 1'b0;
    stop = 1'b0;
    err  = 1'b0;
    tgt  = '0;
    case (int'(addr))
      UA_F0: begin
        ctrl.pc_drv = 1'b1;
        ctrl.mar_ld = 1'b1;
        ctrl.mem_rd = 1'b1;
        ctrl.y_ld   = 1'b1;
      end
      UA_F1: begin
        ctrl.konst     = 4'd4;
        ctrl.konst_drv = 1'b1;
        ctrl.alu       = ALU_ADD;
        ctrl.z_ld      = 1'b1;
      end
      UA_F2: begin
        ctrl.z_drv = 1'b1;
        ctrl.pc_ld = 1'b1;
        hold       = 1'b1;
      end
      UA_F3: begin
        ctrl.mdr_drv = 1'b1;
        ctrl.ir_ld   = 1'b1;
      end
      UA_DISP: begin
        seq = SQ_DISP;
      end
      UA_AI0, UA_LD0: begin
        ctrl.rsel    = RSEL_S;
        ctrl.reg_drv = 1'b1;
        ctrl.y_ld    = 1'b1;
      end
      UA_AI1, UA_LD1: begin
        ctrl.imm_drv = 1'b1;
        ctrl.alu     = ALU_ADD;
        ctrl.z_ld    = 1'b1;
      end
      UA_AI2: begin
        ctrl.z_drv  = 1'b1;
        ctrl.rsel   = RSEL_T;
        ctrl.reg_ld = 1'b1;
        seq         = SQ_GOTO;
        tgt         = ADDR_W'(UA_F0);
      end
      UA_LD2: begin
        ctrl.z_drv  = 1'b1;
        ctrl.mar_ld = 1'b1;
      end
      UA_LD3: begin
        ctrl.mem_rd = 1'b1;
        hold        = 1'b1;
      end
      UA_LD4: begin
        ctrl.mdr_drv = 1'b1;
        ctrl.rsel    = RSEL_T;
        ctrl.reg_ld  = 1'b1;
        seq          = SQ_GOTO;
        tgt          = ADDR_W'(UA_F0);
      end
      UA_HALT: begin
        stop = 1'b1;
      end
      default: begin
        stop = 1'b1;
        err  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter int ADDR_W  = 5,
  parameter int OP_ADDI = 8,
  parameter int OP_LOAD = 35,
  parameter int OP_HALT = 63
) (
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] entry
);

  always_comb begin
    if (opcode == OP_W'(OP_ADDI))      entry = ADDR_W'(UA_AI0);
    else if (opcode == OP_W'(OP_LOAD)) entry = ADDR_W'(UA_LD0);
    else if (opcode == OP_W'(OP_HALT)) entry = ADDR_W'(UA_HALT);
    else                               entry = '1;
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] upc,
  input  seq_e              seq,
  input  logic              hold,
  input  logic              mem_done,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] disp_entry,
  output logic [ADDR_W-1:0] nxt
);

  always_comb begin
    if (hold && !mem_done) begin
      nxt = upc;
    end else begin
      case (seq)
        SQ_GOTO: nxt = tgt;
        SQ_DISP: nxt = disp_entry;
        default: nxt = upc + 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int OP_W    = 6,
  parameter int OP_ADDI = 8,
  parameter int OP_LOAD = 35,
  parameter int OP_HALT = 63,
  localparam int CTRL_W = $bits(ctrl_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   ir_opcode,
  input  logic              mem_done,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              halted,
  output logic              illegal_op
);

  logic [ADDR_W-1:0] upc;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] disp_entry;
  ctrl_t             ctrl;
  seq_e              seq;
  logic              hold;
  logic              stop;
  logic              err;

  useq_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr (upc),
    .ctrl (ctrl),
    .seq  (seq),
    .hold (hold),
    .stop (stop),
    .err  (err),
    .tgt  (tgt)
  );

  useq_dispatch #(
    .OP_W    (OP_W),
    .ADDR_W  (ADDR_W),
    .OP_ADDI (OP_ADDI),
    .OP_LOAD (OP_LOAD),
    .OP_HALT (OP_HALT)
  ) u_disp (
    .opcode (ir_opcode),
    .entry  (disp_entry)
  );

  useq_next #(.ADDR_W(ADDR_W)) u_next (
    .upc        (upc),
    .seq        (seq),
    .hold       (hold),
    .mem_done   (mem_done),
    .tgt        (tgt),
    .disp_entry (disp_entry),
    .nxt        (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc        <= '0;
      halted     <= 1'b0;
      illegal_op <= 1'b0;
    end else if (!halted) begin
      if (stop) begin
        halted     <= 1'b1;
        illegal_op <= err;
      end else begin
        upc <= nxt;
      end
    end
  end

  assign ctrl_word = halted ? '0 : ctrl;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int OP_W    = 6,
  parameter int OP_ADDI = 8,
  parameter int OP_LOAD = 35,
  parameter int OP_HALT = 63,
  parameter int CTRL_W  = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   ir_opcode,
  input logic              mem_done,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              halted,
  input logic              illegal_op,
  input logic [ADDR_W-1:0] upc,
  input seq_e              seq,
  input logic              hold,
  input logic              stop,
  input logic              err,
  input logic [ADDR_W-1:0] tgt
);

  logic mapped;
  assign mapped = (ir_opcode == OP_W'(OP_ADDI)) || (ir_opcode == OP_W'(OP_LOAD)) ||
                  (ir_opcode == OP_W'(OP_HALT));

  // R3
  hold_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && hold && !mem_done) |=> ($stable(upc) && $stable(ctrl_word)));

  // R4
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !stop && !hold && seq == SQ_STEP) |=> (upc == $past(upc) + 1'b1));

  // R6
  goto_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !stop && seq == SQ_GOTO && (!hold || mem_done)) |=> (upc == $past(tgt)));

  // R5
  disp_addi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && seq == SQ_DISP && ir_opcode == OP_W'(OP_ADDI)) |=> (upc == ADDR_W'(UA_AI0)));

  // R5
  disp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && seq == SQ_DISP && ir_opcode == OP_W'(OP_LOAD)) |=> (upc == ADDR_W'(UA_LD0)));

  // R9
  disp_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && seq == SQ_DISP && !mapped) |=> (upc == {ADDR_W{1'b1}}) ##1 (halted && illegal_op));

  // R8
  stop_sets_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && stop) |=> (halted && (illegal_op == $past(err))));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(illegal_op) && $stable(upc)));

  // R9
  illegal_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> halted);

endmodule

bind useq_ctrl useq_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .OP_W    (OP_W),
  .OP_ADDI (OP_ADDI),
  .OP_LOAD (OP_LOAD),
  .OP_HALT (OP_HALT),
  .CTRL_W  (CTRL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ir_opcode  (ir_opcode),
  .mem_done   (mem_done),
  .ctrl_word  (ctrl_word),
  .halted     (halted),
  .illegal_op (illegal_op),
  .upc        (upc),
  .seq        (seq),
  .hold       (hold),
  .stop       (stop),
  .err        (err),
  .tgt        (tgt)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;

  localparam int CW = 25;
  localparam logic [CW-1:0] W_F0  = 25'h0000449;
  localparam logic [CW-1:0] W_F1  = 25'h0901000;
  localparam logic [CW-1:0] W_F2  = 25'h0002002;
  localparam logic [CW-1:0] W_F3  = 25'h0000024;
  localparam logic [CW-1:0] W_ZERO = 25'h0;
  localparam logic [CW-1:0] W_RD0 = 25'h0008600;
  localparam logic [CW-1:0] W_RD1 = 25'h0005000;
  localparam logic [CW-1:0] W_AI2 = 25'h0012100;
  localparam logic [CW-1:0] W_LD2 = 25'h0002008;
  localparam logic [CW-1:0] W_LD3 = 25'h0000040;
  localparam logic [CW-1:0] W_LD4 = 25'h0010120;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    ir_opcode = 6'h00;
  logic          mem_done = 1'b0;
  logic [CW-1:0] ctrl_word;
  logic          halted;
  logic          illegal_op;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  useq_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ir_opcode  (ir_opcode),
    .mem_done   (mem_done),
    .ctrl_word  (ctrl_word),
    .halted     (halted),
    .illegal_op (illegal_op)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, act cycle %0d exp done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_w(string req, logic [CW-1:0] exp);
    n_chk++;
    if (ctrl_word !== exp) begin
      n_bad++;
      $display("FAIL %s ctrl_word act 0x%07h exp 0x%07h", req, ctrl_word, exp);
    end
  endtask

  task automatic chk_f(string req, logic exp_h, logic exp_i);
    n_chk++;
    if (halted !== exp_h || illegal_op !== exp_i) begin
      n_bad++;
      $display("FAIL %s halted/illegal act %b%b exp %b%b", req, halted, illegal_op, exp_h, exp_i);
    end
  endtask

  // R1, R10: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    mem_done = 1'b0;
    step();
    chk_w("R1 in reset", W_F0);
    step();
    rst_n = 1'b1;
    chk_w("R1 after reset", W_F0);
    chk_f("R1 flags", 1'b0, 1'b0);
  endtask

  // R2, R3, R4, R11, R12: fetch with a hold of n cycles, then dispatch on op
  task automatic t_fetch(logic [5:0] op, int n);
    ir_opcode = 6'h2A;
    mem_done = 1'b1;
    chk_w("R2 fetch0", W_F0);
    step();
    ir_opcode = 6'h23;
    chk_w("R12 fetch1 mem_done ignored", W_F1);
    mem_done = 1'b0;
    step();
    for (int i = 0; i < n; i++) begin
      chk_w("R3 fetch hold", W_F2);
      ir_opcode = 6'(i);
      step();
    end
    chk_w("R3 fetch hold last", W_F2);
    mem_done = 1'b1;
    step();
    mem_done = 1'b0;
    chk_w("R4 fetch3", W_F3);
    ir_opcode = op;
    step();
    chk_w("R2 dispatch word", W_ZERO);
    step();
  endtask

  // R5, R6: add-immediate then microjump back to fetch
  task automatic t_addi();
    t_fetch(6'h08, 3);
    chk_w("R5 addi entry", W_RD0);
    ir_opcode = 6'h3F;
    mem_done = 1'b1;
    step();
    chk_w("R6 addi1 R11", W_RD1);
    step();
    chk_w("R6 addi2", W_AI2);
    mem_done = 1'b0;
    step();
    chk_w("R6 jump to fetch", W_F0);
    chk_f("R6 flags", 1'b0, 1'b0);
  endtask

  // R5, R7: load with a hold
  task automatic t_load(int n);
    t_fetch(6'h23, 0);
    chk_w("R5 load entry", W_RD0);
    step();
    chk_w("R7 load1", W_RD1);
    step();
    chk_w("R7 load2", W_LD2);
    mem_done = 1'b0;
    step();
    for (int i = 0; i < n; i++) begin
      chk_w("R3 load hold", W_LD3);
      step();
    end
    chk_w("R7 load3", W_LD3);
    mem_done = 1'b1;
    step();
    mem_done = 1'b0;
    chk_w("R7 load4", W_LD4);
    step();
    chk_w("R7 jump to fetch", W_F0);
  endtask

  // R8: halt routine
  task automatic t_halt();
    t_fetch(6'h3F, 1);
    chk_w("R8 stop step word", W_ZERO);
    chk_f("R8 stop step flags", 1'b0, 1'b0);
    step();
    chk_f("R8 halted", 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      mem_done = i[0];
      ir_opcode = 6'h08;
      step();
      chk_w("R8 word zero after halt", W_ZERO);
      chk_f("R8 halt sticky", 1'b1, 1'b0);
    end
  endtask

  // R9: unmapped opcode
  task automatic t_illegal();
    t_fetch(6'h11, 2);
    chk_w("R9 error step word", W_ZERO);
    chk_f("R9 error step flags", 1'b0, 1'b0);
    ir_opcode = 6'h08;
    step();
    chk_f("R9 illegal flags", 1'b1, 1'b1);
    chk_w("R9 word zero", W_ZERO);
    step();
    chk_f("R9 flags sticky", 1'b1, 1'b1);
  endtask

  initial begin
    step();
    t_reset();
    t_addi();
    t_load(2);
    t_load(0);
    t_halt();
    t_reset();
    chk_w("R10 restart", W_F0);
    t_illegal();
    t_reset();
    chk_f("R10 flags cleared", 1'b0, 1'b0);
    t_addi();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule